// File: doc/BRIEF.md
# Machine Timer Compare Unit

This block is the single machine-level timer of a processor complex. It holds a free-running 64-bit time count and a 64-bit comparand, and raises one interrupt-pending level whenever the count has reached the comparand. Timers for less privileged modes are not built in hardware. Machine-mode software shares this one comparator among them by reprogramming it.

Both 64-bit values sit in the memory-mapped I/O space rather than in the processor's control registers. They are reached through a 32-bit word interface, one address per half. A write changes only the addressed half. The comparison always uses the registers as they stand, so the pending level tracks a half-updated comparand. For this reason, software changes the comparand in three writes: all-ones into the low half, the new upper word into the high half, then the new lower word into the low half. Because the comparand is 64 bits wide, it never overflows, even in a 32-bit system.

Top module: `mach_timer`

## Requirements
- R1: On reset, the count is zero, the comparand is all-ones, and the pending output is low.
- R2: The count increases by one on each clock edge where `tick_i` is high and no count word is written. It holds otherwise and wraps from all-ones to zero.
- R3: `mtip_o` is high exactly when the count is greater than or equal to the comparand, compared as unsigned 64-bit values. It reflects the registers as updated by the previous clock edge.
- R4: Word select encoding: 0 is count bits 31:0, 1 is count bits 63:32, 2 is comparand bits 31:0, 3 is comparand bits 63:32. `rd_data_o` presents the selected word combinationally.
- R5: A write to one comparand half loads the write data into that half and leaves the other half unchanged.
- R6: A write to one count half loads that half and keeps the other half. In that cycle, the write replaces the tick increment.
- R7: The pending output is a level with no acknowledge. Once high, it stays high until a comparand or count write makes the count smaller than the comparand.
- R8: When the count is below both the old and the new comparand, the three-write update (low all-ones, new high, new low) never raises `mtip_o`.
- R9: After every single half write to the comparand, `mtip_o` follows the half-updated 64-bit comparand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable |
| wr_en_i | input | 1 | Word write strobe |
| word_sel_i | input | 2 | Word select for write and read |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Selected word, combinational |
| mtip_o | output | 1 | Machine timer interrupt pending level |

## Verification
Two functions can fall in the same cycle: a tick increment and a write to a count half. The bench provokes this by raising `tick_i` on the same edge as count writes, both in directed cases and in the random mix. It judges the result by reading back all four words and checking that the written half holds the data exactly, with no added one. It also places the comparand within a few counts of the count. As a result, comparand half writes and ticks make the pending level cross in both directions, and each crossing is compared with a bench model of the unsigned 64-bit relation.

// File: rtl/mach_timer_pkg.sv
package mach_timer_pkg;
  localparam int unsigned DEF_WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CMP_LO = 2'd2,
    SEL_CMP_HI = 2'd3
  } word_sel_e;
endpackage

// File: rtl/mach_timer_counter.sv
module mach_timer_counter #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned FULL_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [FULL_W-1:0] cnt_o
);
  // Replace one half of a full-width value.
  function automatic logic [FULL_W-1:0] load_half(
    input logic [FULL_W-1:0] old_v,
    input logic              hi,
    input logic [WORD_W-1:0] d
  );
    logic [FULL_W-1:0] r;
    r = old_v;
    if (hi) r[FULL_W-1:WORD_W] = d;
    else    r[WORD_W-1:0]      = d;
    return r;
  endfunction

  logic [FULL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)        cnt_d = load_half(cnt_q, wr_hi_i, wr_data_i);
    else if (tick_i) cnt_d = cnt_q + FULL_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mach_timer_cmpreg.sv
module mach_timer_cmpreg #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned FULL_W = 2 * WORD_W,
  localparam int unsigned N_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [FULL_W-1:0] cmp_o
);
  // One independently written register per half.
  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    logic [WORD_W-1:0] half_q;
    logic              sel;
    assign sel = wr_i && (wr_hi_i == (g == 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  half_q <= '1;
      else if (sel) half_q <= wr_data_i;
    end
    assign cmp_o[g*WORD_W +: WORD_W] = half_q;
  end
endmodule

// File: rtl/mach_timer_reach.sv
module mach_timer_reach #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned FULL_W = 2 * WORD_W
) (
  input  logic [FULL_W-1:0] cnt_i,
  input  logic [FULL_W-1:0] cmp_i,
  output logic              hit_o
);
  function automatic logic reached(input logic [FULL_W-1:0] c, input logic [FULL_W-1:0] m);
    return c >= m;
  endfunction

  assign hit_o = reached(cnt_i, cmp_i);
endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mach_timer_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned FULL_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        word_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              mtip_o
);
  word_sel_e         sel;
  logic              cnt_wr, cmp_wr, wr_hi;
  logic [FULL_W-1:0] cnt_q, cmp_q;
  logic              hit;

  assign sel    = word_sel_e'(word_sel_i);
  assign wr_hi  = word_sel_i[0];
  assign cnt_wr = wr_en_i && (sel == SEL_CNT_LO || sel == SEL_CNT_HI);
  assign cmp_wr = wr_en_i && (sel == SEL_CMP_LO || sel == SEL_CMP_HI);

  mach_timer_counter #(.WORD_W(WORD_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_i      (cnt_wr),
    .wr_hi_i   (wr_hi),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_q)
  );

  mach_timer_cmpreg #(.WORD_W(WORD_W)) u_cmpreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cmp_wr),
    .wr_hi_i   (wr_hi),
    .wr_data_i (wr_data_i),
    .cmp_o     (cmp_q)
  );

  mach_timer_reach #(.WORD_W(WORD_W)) u_reach (
    .cnt_i (cnt_q),
    .cmp_i (cmp_q),
    .hit_o (hit)
  );

  always_comb begin
    unique case (sel)
      SEL_CNT_LO: rd_data_o = cnt_q[WORD_W-1:0];
      SEL_CNT_HI: rd_data_o = cnt_q[FULL_W-1:WORD_W];
      SEL_CMP_LO: rd_data_o = cmp_q[WORD_W-1:0];
      default:    rd_data_o = cmp_q[FULL_W-1:WORD_W];
    endcase
  end

  assign mtip_o = hit;
endmodule

// File: rtl/mach_timer_chk.sv
module mach_timer_chk #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned FULL_W = 2 * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              cnt_wr,
  input logic              cmp_wr,
  input logic              wr_hi,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [FULL_W-1:0] cnt_q,
  input logic [FULL_W-1:0] cmp_q,
  input logic              mtip_o
);
  a_r1_reset_values: assert property (@(posedge clk_i)
    !rst_ni |=> (cnt_q == '0 && cmp_q == '1 && !mtip_o));

  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr) |=> cnt_q == $past(cnt_q) + FULL_W'(1));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(cnt_q));

  a_r5_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr && !wr_hi) |=> (cmp_q[WORD_W-1:0] == $past(wr_data_i) &&
                            cmp_q[FULL_W-1:WORD_W] == $past(cmp_q[FULL_W-1:WORD_W])));

  a_r5_high_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr && wr_hi) |=> (cmp_q[FULL_W-1:WORD_W] == $past(wr_data_i) &&
                           cmp_q[WORD_W-1:0] == $past(cmp_q[WORD_W-1:0])));

  a_r6_count_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && !wr_hi) |=> (cnt_q[WORD_W-1:0] == $past(wr_data_i) &&
                            cnt_q[FULL_W-1:WORD_W] == $past(cnt_q[FULL_W-1:WORD_W])));

  a_r5_cmp_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_wr |=> $stable(cmp_q));

  a_r7_level_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtip_o && !cmp_wr && !cnt_wr && cnt_q != '1) |=> mtip_o);

  a_r7_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mtip_o) |-> $past(cmp_wr || cnt_wr || cnt_q == '1));
endmodule

bind mach_timer mach_timer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .cnt_wr    (cnt_wr),
  .cmp_wr    (cmp_wr),
  .wr_hi     (wr_hi),
  .wr_data_i (wr_data_i),
  .cnt_q     (cnt_q),
  .cmp_q     (cmp_q),
  .mtip_o    (mtip_o)
);

// File: tb/mach_timer_bench.sv
module mach_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  logic [63:0] m_cnt, m_cmp;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mach_timer u_mach_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
    .word_sel_i(sel), .wr_data_i(wdata), .rd_data_o(rdata), .mtip_o(irq)
  );

  function automatic logic want_irq(input logic [63:0] c, input logic [63:0] m);
    return !(c < m);
  endfunction

  function automatic logic [31:0] want_word(input logic [1:0] s);
    case (s)
      2'd0: return m_cnt[31:0];
      2'd1: return m_cnt[63:32];
      2'd2: return m_cmp[31:0];
      default: return m_cmp[63:32];
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive one cycle on the falling edge, update the model at the rising edge.
  task automatic cyc(input logic w, input logic [1:0] s, input logic [31:0] d, input logic t);
    @(negedge clk);
    we = w; sel = s; wdata = d; tick = t;
    @(posedge clk);
    if (w && s == 2'd0)      m_cnt = {m_cnt[63:32], d};
    else if (w && s == 2'd1) m_cnt = {d, m_cnt[31:0]};
    else if (t)              m_cnt = m_cnt + 64'd1;
    if (w && s == 2'd2) m_cmp = {m_cmp[63:32], d};
    if (w && s == 2'd3) m_cmp = {d, m_cmp[31:0]};
    #1;
    we = 1'b0; tick = 1'b0;
  endtask

  task automatic check_irq(input string req);
    chk(req, {63'd0, irq}, {63'd0, want_irq(m_cnt, m_cmp)});
  endtask

  task automatic check_words(input string req);
    for (int i = 0; i < 4; i++) begin
      sel = 2'(i);
      #1;
      chk(req, {32'd0, rdata}, {32'd0, want_word(2'(i))});
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = '0;
    m_cmp = '1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check_words("R1");
    chk("R1", {63'd0, irq}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: ticks increment, idle holds
    repeat (5) cyc(1'b0, 2'd0, 32'd0, 1'b1);
    cyc(1'b0, 2'd0, 32'd0, 1'b0);
    check_words("R2");

    // R4/R9: compare high then low, pending follows halves
    cyc(1'b1, 2'd3, 32'd0, 1'b0);
    check_irq("R9");
    cyc(1'b1, 2'd2, 32'd8, 1'b0);
    check_irq("R9");
    check_words("R4");
    repeat (3) begin
      cyc(1'b0, 2'd0, 32'd0, 1'b1);
      check_irq("R3");
    end
    chk("R3", {63'd0, irq}, 64'd1);

    // R7: level held without acknowledge
    repeat (4) begin
      cyc(1'b0, 2'd0, 32'd0, 1'b0);
      chk("R7", {63'd0, irq}, 64'd1);
    end
    cyc(1'b1, 2'd2, 32'd100, 1'b0);
    chk("R7", {63'd0, irq}, 64'd0);

    // R6: tick collides with count write; write wins
    cyc(1'b1, 2'd0, 32'h0000_0050, 1'b1);
    check_words("R6");
    chk("R6", m_cnt, 64'h50);
    cyc(1'b1, 2'd1, 32'h0000_0002, 1'b1);
    check_words("R6");
    check_irq("R6");

    // R8: safe update sequence, count below old and new
    cyc(1'b1, 2'd1, 32'd0, 1'b0);
    cyc(1'b1, 2'd0, 32'd10, 1'b0);
    cyc(1'b1, 2'd3, 32'd0, 1'b0);
    cyc(1'b1, 2'd2, 32'd500, 1'b0);
    chk("R8", {63'd0, irq}, 64'd0);
    cyc(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b1);
    chk("R8", {63'd0, irq}, 64'd0);
    cyc(1'b1, 2'd3, 32'd1, 1'b1);
    chk("R8", {63'd0, irq}, 64'd0);
    cyc(1'b1, 2'd2, 32'd20, 1'b1);
    chk("R8", {63'd0, irq}, 64'd0);
    check_words("R8");

    // R5: one half only
    cyc(1'b1, 2'd3, 32'hA5A5_0000, 1'b0);
    chk("R5", m_cmp, 64'hA5A5_0000_0000_0014);
    check_words("R5");

    // R2: wrap from all-ones
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0);
    check_irq("R3");
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    chk("R2", m_cnt, 64'd0);
    check_words("R2");
    check_irq("R3");

    // Random mix near the crossing point
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  s;
      logic [31:0] d;
      logic        w, t;
      int          r;
      s = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 3) == 0);
      t = ($urandom_range(0, 1) == 1);
      r = $urandom_range(0, 5);
      if (s[0]) d = (r < 4) ? m_cnt[63:32] + 32'(r / 2) : $urandom();
      else      d = (r < 4) ? m_cnt[31:0] + 32'(r) : $urandom();
      cyc(w, s, d, t);
      check_irq(w && s[1] ? "R9" : "R3");
      if (n % 16 == 0) check_words(t && w && !s[1] ? "R6" : "R4");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule